// File: doc/BRIEF.md
# ECP Reverse-Channel Host Receiver

This block is the host end of a bidirectional parallel port running in ECP mode with data flowing from the peripheral to the host. It runs the per-byte handshake without software help. It samples the peripheral strobe and the 8-bit data bus and drives the host acknowledge line. Each received byte goes into a 16-entry byte FIFO. A small CPU bus reads that FIFO and a status register, and it programs a fill threshold that raises a service interrupt.

While the FIFO is full, the block holds the acknowledge line high, which stalls the peripheral so that no byte is lost. Software ends a transfer by writing a stop request. The block then drives the reverse-request line high and waits for the peripheral to raise its acknowledge-reverse line. On success it reports forward idle and latches how many bytes were still unread, which is the residue. Every wait on a peripheral edge is bounded by a timeout. Selecting any mode other than FIFO mode clears the FIFO and the handshake.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset the mode is 0, the host acknowledge and reverse-request outputs are both 1, and status reads with empty=1 (bit 0), full=0 (bit 1), service flag=1 (bit 2), error=0 (bit 3) and forward-idle=0 (bit 4).
- R2: In FIFO mode (mode field bits [7:5] of address 0 equal to 3), the reverse-request output is 0 and host acknowledge is 0. When the peripheral strobe goes low, the data byte is stored and host acknowledge goes to 1. When the strobe returns high, host acknowledge goes back to 0.
- R3: With 16 bytes stored, host acknowledge stays at 1 after the strobe returns high and no further byte is taken. One read from the FIFO lets the handshake resume.
- R4: Status bit 0 is 1 exactly when the FIFO is empty, and status bit 1 is 1 exactly when it holds 16 bytes.
- R5: Reads of address 1 return the bytes in arrival order, either one at a time or as a full burst of 16. A read while the FIFO is empty returns 0 and changes nothing.
- R6: Writing address 0 with bit 2 equal to 0 clears the service flag. Once the fill count reaches the threshold in address 2 bits [3:0], the flag returns to 1 and a one-cycle interrupt pulse is issued. Writing bit 2 equal to 1 leaves the flag unchanged.
- R7: Writing address 0 with bit 4 set in FIFO mode drives the reverse-request output to 1. When the peripheral's acknowledge-reverse input goes high, status bit 4 becomes 1 and address 3 holds the number of unread FIFO bytes.
- R8: If the strobe stays low, or the acknowledge-reverse input stays low after a stop request, for TIMEOUT cycles, status bit 3 becomes 1. Host acknowledge and reverse-request then stay at 1 until the mode is changed.
- R9: Any mode other than 3 empties the FIFO, clears the error and forward-idle flags, and drives host acknowledge and reverse-request to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nack_in | input | 1 | Peripheral strobe, low while data is valid (asynchronous) |
| perr_in | input | 1 | Peripheral acknowledge-reverse, high for forward idle (asynchronous) |
| pdata_in | input | 8 | Parallel data bus from the peripheral |
| host_ack_out | output | 1 | Host acknowledge to the peripheral |
| init_out | output | 1 | Reverse-request line, 0 while in reverse |
| bus_addr | input | 2 | CPU register select: 0 control/status, 1 FIFO, 2 threshold, 3 residue |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe (pops the FIFO at address 1) |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data, combinational from bus_addr |
| irq | output | 1 | One-cycle service interrupt pulse |

## Verification
If the FIFO count is wrong, the full and empty status bits disagree with the number of bytes written and read within one cycle. The effect at the pins is visible at once: host acknowledge stays high with fewer than 16 bytes stored, or drops with 16 stored. A corrupted read or write pointer shows on the next FIFO read as a byte out of order. A handshake stuck in the wrong state shows within a few cycles as host acknowledge failing to follow the strobe. A wrong threshold comparison moves the service flag and the interrupt pulse to a different byte of the transfer.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;
    typedef enum logic [2:0] {
        HS_OFF,
        HS_WAIT,
        HS_ACK,
        HS_TERM,
        HS_FWD,
        HS_ABORT
    } hs_state_e;

    localparam logic [2:0] MODE_FIFO = 3'd3;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_FIFO = 2'd1;
    localparam logic [1:0] A_THR  = 2'd2;
    localparam logic [1:0] A_RES  = 2'd3;
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
    parameter int          W      = 2,
    parameter logic [W-1:0] RSTVAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RSTVAL, s2: RSTVAL};
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/ecp_fifo.sv
module ecp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_s;

    fifo_s f_d, f_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty   = (f_q.cnt == '0);
    assign full    = (f_q.cnt == CW'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_comb begin
        f_d = f_q;
        if (clr) begin
            f_d = '0;
        end else begin
            if (do_push) f_d.wp = (f_q.wp == AW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
            if (do_pop)  f_d.rp = (f_q.rp == AW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
            if (do_push && !do_pop)      f_d.cnt = f_q.cnt + 1'b1;
            else if (do_pop && !do_push) f_d.cnt = f_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[f_q.wp] <= wdata;
    end

    assign rdata = empty ? '0 : mem_q[f_q.rp];
    assign count = f_q.cnt;

    a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> !full);
    a_r5_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push && !clr) |=> (count == $past(count) - 1'b1));
    a_r5_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/ecp_hs_fsm.sv
module ecp_hs_fsm
    import ecp_rx_pkg::*;
#(
    parameter int TIMEOUT = 200,
    localparam int TW     = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stop,
    input  logic nack_s,
    input  logic perr_s,
    input  logic fifo_full,
    output logic push,
    output logic done,
    output logic host_ack,
    output logic init_line,
    output logic is_fwd,
    output logic is_abort
);
    typedef struct packed {
        hs_state_e     st;
        logic [TW-1:0] cnt;
    } fsm_s;

    fsm_s s_d, s_q;

    always_comb begin
        s_d  = s_q;
        push = 1'b0;
        done = 1'b0;
        if (!en) begin
            s_d.st  = HS_OFF;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.st)
                HS_OFF: begin
                    s_d.st  = HS_WAIT;
                    s_d.cnt = '0;
                end
                HS_WAIT: begin
                    if (stop) begin
                        s_d.st  = HS_TERM;
                        s_d.cnt = '0;
                    end else if (!nack_s) begin
                        push    = 1'b1;
                        s_d.st  = HS_ACK;
                        s_d.cnt = '0;
                    end
                end
                HS_ACK: begin
                    if (stop) begin
                        s_d.st  = HS_TERM;
                        s_d.cnt = '0;
                    end else if (nack_s) begin
                        s_d.cnt = '0;
                        if (!fifo_full) s_d.st = HS_WAIT;
                    end else if (s_q.cnt == TW'(TIMEOUT - 1)) begin
                        s_d.st = HS_ABORT;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                HS_TERM: begin
                    if (perr_s) begin
                        s_d.st = HS_FWD;
                        done   = 1'b1;
                    end else if (s_q.cnt == TW'(TIMEOUT - 1)) begin
                        s_d.st = HS_ABORT;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: HS_OFF, cnt: '0};
        else        s_q <= s_d;
    end

    assign host_ack  = (s_q.st != HS_WAIT);
    assign init_line = !(s_q.st == HS_WAIT || s_q.st == HS_ACK);
    assign is_fwd    = (s_q.st == HS_FWD);
    assign is_abort  = (s_q.st == HS_ABORT);

    a_r2_push_raises_ack: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> host_ack);
    a_r3_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == HS_ACK && fifo_full && en && !stop) |=> host_ack);
    a_r7_fwd_needs_perr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_fwd) |-> $past(perr_s));
    a_r8_abort_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_abort) |-> ($past(s_q.cnt) == TW'(TIMEOUT - 1)));
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
    import ecp_rx_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TIMEOUT = 200,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int THW    = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nack_in,
    input  logic       perr_in,
    input  logic [7:0] pdata_in,
    output logic       host_ack_out,
    output logic       init_out,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    typedef struct packed {
        logic [2:0]     mode;
        logic [THW-1:0] thr;
        logic           svc;
        logic [CW-1:0]  res;
        logic           irq;
    } regs_s;

    regs_s r_d, r_q;

    logic [1:0]    syn_q;
    logic          nack_s, perr_s;
    logic          en, stop, push, done, pop;
    logic          ctrl_wr, arm;
    logic          f_empty, f_full, fwd, abrt;
    logic [7:0]    f_rdata;
    logic [CW-1:0] f_count;

    ecp_sync #(.W(2), .RSTVAL(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({perr_in, nack_in}), .q(syn_q)
    );
    assign nack_s = syn_q[0];
    assign perr_s = syn_q[1];

    assign en      = (r_q.mode == MODE_FIFO);
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign arm     = ctrl_wr && !bus_wdata[2];
    assign stop    = ctrl_wr && bus_wdata[4] && (bus_wdata[7:5] == MODE_FIFO);
    assign pop     = bus_rd && (bus_addr == A_FIFO) && en;

    ecp_hs_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .stop(stop),
        .nack_s(nack_s), .perr_s(perr_s), .fifo_full(f_full),
        .push(push), .done(done), .host_ack(host_ack_out),
        .init_line(init_out), .is_fwd(fwd), .is_abort(abrt)
    );

    ecp_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(!en), .push(push), .wdata(pdata_in),
        .pop(pop), .rdata(f_rdata), .count(f_count),
        .empty(f_empty), .full(f_full)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        if (ctrl_wr) r_d.mode = bus_wdata[7:5];
        if (bus_wr && bus_addr == A_THR) r_d.thr = bus_wdata[THW-1:0];
        if (arm) begin
            r_d.svc = 1'b0;
        end else if (!r_q.svc && en && (f_count >= CW'(r_q.thr))) begin
            r_d.svc = 1'b1;
            r_d.irq = 1'b1;
        end
        if (!en)       r_d.res = '0;
        else if (done) r_d.res = f_count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{mode: 3'd0, thr: '0, svc: 1'b1, res: '0, irq: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {r_q.mode, fwd, abrt, r_q.svc, f_full, f_empty};
            A_FIFO:  bus_rdata = f_rdata;
            A_THR:   bus_rdata = 8'(r_q.thr);
            default: bus_rdata = 8'(r_q.res);
        endcase
    end

    assign irq = r_q.irq;

    a_r9_leave_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> f_empty);
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.svc && !arm) |=> r_q.svc);
    a_r6_irq_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(r_q.svc) == 1'b0 && r_q.svc));
    a_r4_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_full && f_empty));
endmodule

// File: tb/ecp_rev_rx_test.sv
`timescale 1ns/100ps
module ecp_rev_rx_test;
    localparam int TO = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nack_in = 1'b1;
    logic       perr_in = 1'b1;
    logic [7:0] pdata_in = '0;
    logic       host_ack_out, init_out, irq;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;

    int total = 0, bad = 0, irq_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ecp_rev_rx #(.DEPTH(16), .TIMEOUT(TO)) uut (
        .clk(clk), .rst_n(rst_n), .nack_in(nack_in), .perr_in(perr_in),
        .pdata_in(pdata_in), .host_ack_out(host_ack_out), .init_out(init_out),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) if (irq) irq_cnt++;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_ack(input logic v, input string tag);
        int n = 0;
        while (host_ack_out !== v && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (n >= 400) chk(tag, host_ack_out, v);
    endtask

    task automatic send(input logic [7:0] b);
        wait_ack(1'b0, "R2 ack low before byte");
        pdata_in = b; nack_in = 1'b0;
        wait_ack(1'b1, "R2 ack high after strobe");
        @(negedge clk);
        nack_in = 1'b1;
        @(negedge clk);
    endtask

    task automatic restart(input logic [7:0] ctrl);
        wr(2'd0, 8'h04);
        perr_in = 1'b0;
        wr(2'd0, ctrl);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v);
        chk("R1 status", v, 8'h05);
        chk("R1 host_ack", host_ack_out, 1);
        chk("R1 init", init_out, 1);

        // R2 handshake, R4 status bits
        restart(8'h64);
        chk("R2 init low in reverse", init_out, 0);
        chk("R2 ack low idle", host_ack_out, 0);
        pdata_in = 8'h3C; nack_in = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2 ack high while strobe low", host_ack_out, 1);
        nack_in = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 ack low after strobe high", host_ack_out, 0);
        rd(2'd0, v);
        chk("R4 one byte not empty", v[1:0], 2'b00);
        rd(2'd1, v);
        chk("R5 single read", v, 8'h3C);
        rd(2'd0, v);
        chk("R4 empty after read", v[1:0], 2'b01);

        // R3/R5 full stall and burst order
        restart(8'h64);
        for (int i = 0; i < 16; i++) send(8'hA0 + 8'(i));
        rd(2'd0, v);
        chk("R4 full bit", v[1:0], 2'b10);
        repeat (20) @(negedge clk);
        chk("R3 ack held while full", host_ack_out, 1);
        rd(2'd1, v);
        chk("R5 first byte", v, 8'hA0);
        repeat (8) @(negedge clk);
        chk("R3 resume after read", host_ack_out, 0);
        send(8'hB0);
        for (int i = 1; i < 17; i++) begin
            rd(2'd1, v);
            chk("R5 burst order", v, (i < 16) ? (8'hA0 + i) : 8'hB0);
        end
        rd(2'd0, v);
        chk("R4 empty after burst", v[1:0], 2'b01);
        rd(2'd1, v);
        chk("R5 empty read value", v, 0);
        rd(2'd0, v);
        chk("R5 empty read no change", v[1:0], 2'b01);
        send(8'hC5);
        rd(2'd1, v);
        chk("R5 pointers intact", v, 8'hC5);

        // R6 threshold sweep
        for (int t = 1; t < 16; t++) begin
            wr(2'd0, 8'h04);
            wr(2'd2, 8'(t));
            perr_in = 1'b0;
            wr(2'd0, 8'h60);
            irq_cnt = 0;
            repeat (3) @(negedge clk);
            rd(2'd0, v);
            chk("R6 armed flag clear", v[2], 0);
            for (int k = 1; k <= t + 1; k++) begin
                send(8'(k));
                repeat (3) @(negedge clk);
                rd(2'd0, v);
                chk("R6 flag vs fill", v[2], (k >= t) ? 1 : 0);
            end
            chk("R6 single irq", irq_cnt, 1);
        end
        restart(8'h64);
        wr(2'd2, 8'd2);
        wr(2'd0, 8'h64);
        rd(2'd0, v);
        chk("R6 bit2 one keeps flag", v[2], 1);

        // R7 termination and residue
        restart(8'h64);
        for (int i = 0; i < 5; i++) send(8'h10 + 8'(i));
        rd(2'd1, v);
        rd(2'd1, v);
        wr(2'd0, 8'h74);
        repeat (3) @(negedge clk);
        chk("R7 init high on stop", init_out, 1);
        rd(2'd0, v);
        chk("R7 not idle before perr", v[4], 0);
        perr_in = 1'b1;
        repeat (5) @(negedge clk);
        rd(2'd0, v);
        chk("R7 forward idle", v[4], 1);
        chk("R7 no error", v[3], 0);
        rd(2'd3, v);
        chk("R7 residue", v, 3);

        // R8 timeouts
        restart(8'h64);
        pdata_in = 8'h55; nack_in = 1'b0;
        repeat (TO + 10) @(negedge clk);
        rd(2'd0, v);
        chk("R8 strobe timeout err", v[3], 1);
        nack_in = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 ack stays high", host_ack_out, 1);
        chk("R8 init high", init_out, 1);
        restart(8'h64);
        wr(2'd0, 8'h74);
        repeat (TO + 10) @(negedge clk);
        rd(2'd0, v);
        chk("R8 perr timeout err", v[3], 1);
        chk("R8 perr timeout no idle", v[4], 0);

        // R9 mode change clears
        restart(8'h64);
        send(8'h77);
        send(8'h78);
        wr(2'd0, 8'h24);
        repeat (2) @(negedge clk);
        rd(2'd0, v);
        chk("R9 cleared status", v, 8'h25);
        chk("R9 ack high", host_ack_out, 1);
        chk("R9 init high", init_out, 1);
        wr(2'd0, 8'h64);
        repeat (3) @(negedge clk);
        rd(2'd0, v);
        chk("R9 empty on reentry", v[0], 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule